// File: doc/BRIEF.md
# Capture Event and Overflow Linkage Router

This block sits between a group of bandwidth monitors and the sources that can tell them to snapshot their counts. Each monitor owns two 3-bit selectors. The linkage selector decides whether the monitor's overflow pulse is also sent out as one of six shared capture events. The capture selector decides which event makes that monitor capture. It can pick no event, one of the six shared events, or a software capture strobe that matches the monitor's security state. The monitors' counters, capture registers and overflow logic are outside this block. The block only routes pulses.

A shared event is the OR of its external input and every overflow pulse whose linkage selector names it. Event sources that are not implemented are masked by a parameter. An unimplemented event never reaches any monitor, whether it comes from the external pin or from linkage. Each monitor's capture request is registered into a one-cycle pulse. A linked overflow therefore reaches every listening monitor one clock after the overflow. The selectors are written through a simple indexed write port and read back through an indexed combinational read port.

Top module: `capt_evt_router`

## Requirements
- R1: After reset, every capture output is 0 and every linkage and capture selector reads back as 0.
- R2: A write with `cfg_we` high stores `cfg_link` and `cfg_capt` into the monitor numbered `cfg_idx`. The stored values read back on `rd_link`/`rd_capt` from the next cycle and are used for routing from the next cycle. An index of `NUM_MON` or higher is ignored.
- R3: A monitor whose bit in `CAPT_MASK` is 0 has no capture support. Its capture selector always reads 0, writes to it are ignored, and it never pulses `capt_o`.
- R4: Capture selector code 0 never produces a capture pulse for that monitor.
- R5: Capture selector code n (1 to 6) makes `capt_o[m]` high in the cycle after the one in which shared event n is active. External event n is `ext_evt_i[n-1]`.
- R6: Linkage code n (1 to 6) makes an overflow pulse `ovf_i[m]` act as shared event n in the same cycle. Every monitor selecting n then captures one cycle later.
- R7: Linkage codes 0 and 7 add nothing to any shared event.
- R8: Capture selector code 7 captures one cycle after `sw_capt_we` is high with `sw_capt_sec` equal to that monitor's security tag (`mon_sec_i[2m+1:2m]`). With any other tag it does not capture.
- R9: `SRC_IMPL` bit n-1 enables shared event n (n = 1 to 6), and bit 6 enables the software strobe. A source whose bit is 0 never causes a capture, either from its input or through linkage.
- R10: A monitor whose own overflow drives the event it selects receives a single one-cycle capture pulse for that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Selector write strobe |
| cfg_idx | input | 3 | Monitor number written |
| cfg_link | input | 3 | Linkage selector value written |
| cfg_capt | input | 3 | Capture selector value written |
| rd_idx | input | 3 | Monitor number read back |
| rd_link | output | 3 | Linkage selector of monitor `rd_idx` |
| rd_capt | output | 3 | Capture selector of monitor `rd_idx` |
| mon_sec_i | input | 16 | Security tag of each monitor, 2 bits per monitor |
| ovf_i | input | 8 | Per-monitor overflow pulses |
| ext_evt_i | input | 6 | External capture events 1 to 6 |
| sw_capt_we | input | 1 | Software capture-register write strobe |
| sw_capt_sec | input | 2 | Security tag of the software write |
| capt_o | output | 8 | Per-monitor one-cycle capture pulses |

## Verification
Directed cases apply one source at a time:
- A lone external pulse.
- A lone linked overflow.
- A software strobe with a matching tag, then with a mismatched tag.

Each case shows that exactly the selected monitors respond, one cycle late. Reserved linkage code 7, an unimplemented event and a monitor without capture support are each driven so that the only possible capture would be a wrong one. A monitor that both links to and listens on the same event has its overflow raised together with the external copy of that event, which separates a single merged pulse from a doubled or stretched one. Random cycles then mix selector rewrites with overlapping external, overflow and software pulses, so that routing through stale selectors or missed OR terms shows up against the bench model.

// File: rtl/capt_evt_pkg.sv
package capt_evt_pkg;

  localparam int unsigned N_EVT   = 6;
  localparam int unsigned SEL_W   = 3;
  localparam int unsigned SRC_W   = N_EVT + 1;
  localparam int unsigned SW_BIT  = N_EVT;

  typedef logic [SEL_W-1:0] sel_t;

  localparam sel_t LINK_NONE = 3'd0;
  localparam sel_t LINK_RSVD = 3'd7;
  localparam sel_t CAPT_NONE = 3'd0;
  localparam sel_t CAPT_SW   = 3'd7;

endpackage

// File: rtl/evt_cfg_store.sv
module evt_cfg_store
  import capt_evt_pkg::*;
#(
  parameter int unsigned          NUM_MON   = 8,
  parameter logic [NUM_MON-1:0]   CAPT_MASK = '1,
  localparam int unsigned         IDX_W     = (NUM_MON > 1) ? $clog2(NUM_MON) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  sel_t             wr_link,
  input  sel_t             wr_capt,
  output sel_t             link_q [NUM_MON],
  output sel_t             capt_q [NUM_MON]
);

  sel_t link_d [NUM_MON];
  sel_t capt_d [NUM_MON];
  logic [NUM_MON-1:0] hit;

  always_comb begin
    for (int m = 0; m < NUM_MON; m++) begin
      hit[m]    = wr_en && ({1'b0, wr_idx} == (IDX_W+1)'(m));
      link_d[m] = link_q[m];
      capt_d[m] = capt_q[m];
      if (hit[m]) begin
        link_d[m] = wr_link;
        capt_d[m] = CAPT_MASK[m] ? wr_capt : CAPT_NONE;
      end
    end
  end

  generate
    for (genvar g = 0; g < NUM_MON; g++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          link_q[g] <= LINK_NONE;
          capt_q[g] <= CAPT_NONE;
        end else if (hit[g]) begin
          link_q[g] <= link_d[g];
          capt_q[g] <= capt_d[g];
        end
      end

      AST_LINK_STORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && {1'b0, wr_idx} == (IDX_W+1)'(g)) |=> (link_q[g] == $past(wr_link))); // R2

      if (!CAPT_MASK[g]) begin : g_nocapt
        AST_NOCAPT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
          (wr_en && {1'b0, wr_idx} == (IDX_W+1)'(g)) |=> (capt_q[g] == CAPT_NONE)); // R3
      end
    end
  endgenerate

endmodule

// File: rtl/evt_combine.sv
module evt_combine
  import capt_evt_pkg::*;
#(
  parameter int unsigned      NUM_MON  = 8,
  parameter logic [SRC_W-1:0] SRC_IMPL = '1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_MON-1:0] ovf,
  input  sel_t               link [NUM_MON],
  input  logic [N_EVT-1:0]   ext,
  output logic [N_EVT-1:0]   evt
);

  logic [N_EVT-1:0] raw;

  always_comb begin
    raw = ext;
    for (int m = 0; m < NUM_MON; m++) begin
      for (int n = 1; n <= N_EVT; n++) begin
        if (ovf[m] && (link[m] == sel_t'(n))) raw[n-1] = 1'b1;
      end
    end
    evt = raw & SRC_IMPL[N_EVT-1:0];
  end

  logic linked_any;
  always_comb begin
    linked_any = 1'b0;
    for (int m = 0; m < NUM_MON; m++)
      if (ovf[m] && link[m] != LINK_NONE && link[m] != LINK_RSVD) linked_any = 1'b1;
  end

  AST_QUIET_LINKS: assert property (@(posedge clk) disable iff (!rst_n)
    (ext == '0 && !linked_any) |-> (evt == '0)); // R7

endmodule

// File: rtl/capt_decode.sv
module capt_decode
  import capt_evt_pkg::*;
#(
  parameter int unsigned        NUM_MON   = 8,
  parameter int unsigned        SEC_W     = 2,
  parameter logic [NUM_MON-1:0] CAPT_MASK = '1,
  parameter logic [SRC_W-1:0]   SRC_IMPL  = '1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_EVT-1:0]   evt,
  input  logic               sw_we,
  input  logic [SEC_W-1:0]   sw_sec,
  input  logic [SEC_W-1:0]   mon_sec [NUM_MON],
  input  sel_t               capt_sel [NUM_MON],
  output logic [NUM_MON-1:0] capt_q
);

  logic [NUM_MON-1:0] capt_d;

  always_comb begin
    for (int m = 0; m < NUM_MON; m++) begin
      capt_d[m] = 1'b0;
      if (capt_sel[m] == CAPT_SW) begin
        capt_d[m] = sw_we && SRC_IMPL[SW_BIT] && (sw_sec == mon_sec[m]);
      end else begin
        for (int n = 1; n <= N_EVT; n++)
          if (capt_sel[m] == sel_t'(n)) capt_d[m] = evt[n-1];
      end
      capt_d[m] = capt_d[m] && CAPT_MASK[m];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) capt_q <= '0;
    else        capt_q <= capt_d;
  end

  generate
    for (genvar g = 0; g < NUM_MON; g++) begin : g_chk
      AST_SEL_NONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (capt_sel[g] == CAPT_NONE) |=> !capt_q[g]); // R4
      AST_SW_TAG_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (capt_sel[g] == CAPT_SW && !(sw_we && sw_sec == mon_sec[g])) |=> !capt_q[g]); // R8
      if (CAPT_MASK[g]) begin : g_sup
        AST_EVT_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
          (capt_sel[g] != CAPT_NONE && capt_sel[g] != CAPT_SW && evt[capt_sel[g] - 3'd1])
          |=> capt_q[g]); // R5
      end
    end
  endgenerate

endmodule

// File: rtl/capt_evt_router.sv
module capt_evt_router
  import capt_evt_pkg::*;
#(
  parameter int unsigned        NUM_MON   = 8,
  parameter int unsigned        SEC_W     = 2,
  parameter logic [NUM_MON-1:0] CAPT_MASK = 8'b0111_1111,
  parameter logic [6:0]         SRC_IMPL  = 7'b101_1111,
  localparam int unsigned       IDX_W     = (NUM_MON > 1) ? $clog2(NUM_MON) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_we,
  input  logic [IDX_W-1:0]         cfg_idx,
  input  logic [2:0]               cfg_link,
  input  logic [2:0]               cfg_capt,
  input  logic [IDX_W-1:0]         rd_idx,
  output logic [2:0]               rd_link,
  output logic [2:0]               rd_capt,
  input  logic [NUM_MON*SEC_W-1:0] mon_sec_i,
  input  logic [NUM_MON-1:0]       ovf_i,
  input  logic [5:0]               ext_evt_i,
  input  logic                     sw_capt_we,
  input  logic [SEC_W-1:0]         sw_capt_sec,
  output logic [NUM_MON-1:0]       capt_o
);

  sel_t             link_q  [NUM_MON];
  sel_t             capt_q  [NUM_MON];
  logic [SEC_W-1:0] mon_sec [NUM_MON];
  logic [N_EVT-1:0] evt;

  generate
    for (genvar g = 0; g < NUM_MON; g++) begin : g_sec
      assign mon_sec[g] = mon_sec_i[g*SEC_W +: SEC_W];
    end
  endgenerate

  evt_cfg_store #(.NUM_MON(NUM_MON), .CAPT_MASK(CAPT_MASK)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .wr_idx(cfg_idx),
    .wr_link(cfg_link), .wr_capt(cfg_capt), .link_q(link_q), .capt_q(capt_q)
  );

  evt_combine #(.NUM_MON(NUM_MON), .SRC_IMPL(SRC_IMPL)) u_comb (
    .clk(clk), .rst_n(rst_n), .ovf(ovf_i), .link(link_q), .ext(ext_evt_i), .evt(evt)
  );

  capt_decode #(.NUM_MON(NUM_MON), .SEC_W(SEC_W), .CAPT_MASK(CAPT_MASK),
                .SRC_IMPL(SRC_IMPL)) u_dec (
    .clk(clk), .rst_n(rst_n), .evt(evt), .sw_we(sw_capt_we), .sw_sec(sw_capt_sec),
    .mon_sec(mon_sec), .capt_sel(capt_q), .capt_q(capt_o)
  );

  always_comb begin
    rd_link = LINK_NONE;
    rd_capt = CAPT_NONE;
    if ({1'b0, rd_idx} < (IDX_W+1)'(NUM_MON)) begin
      rd_link = link_q[rd_idx];
      rd_capt = capt_q[rd_idx];
    end
  end

  AST_IDLE_NO_CAPT: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_i == '0 && ext_evt_i == '0 && !sw_capt_we) |=> (capt_o == '0)); // R9

endmodule

// File: tb/capt_evt_router_tb.sv
module capt_evt_router_tb_top;

  localparam logic [7:0] CMASK = 8'b0111_1111;
  localparam logic [6:0] IMPL  = 7'b101_1111;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cfg_we;
  logic [2:0] cfg_idx, cfg_link, cfg_capt, rd_idx, rd_link, rd_capt;
  logic [15:0] mon_sec_i;
  logic [7:0] ovf_i, capt_o;
  logic [5:0] ext_evt_i;
  logic       sw_capt_we;
  logic [1:0] sw_capt_sec;

  int checks = 0;
  int errors = 0;
  logic [2:0] m_link [8];
  logic [2:0] m_capt [8];

  always #10 clk = ~clk;

  capt_evt_router dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_link(cfg_link),
    .cfg_capt(cfg_capt), .rd_idx(rd_idx), .rd_link(rd_link), .rd_capt(rd_capt),
    .mon_sec_i(mon_sec_i), .ovf_i(ovf_i), .ext_evt_i(ext_evt_i),
    .sw_capt_we(sw_capt_we), .sw_capt_sec(sw_capt_sec), .capt_o(capt_o)
  );

  function automatic logic [1:0] sec_of(int m);
    return 2'(m % 4);
  endfunction

  function automatic logic [7:0] model(logic [7:0] ovf, logic [5:0] ext,
                                       logic swe, logic [1:0] sws);
    logic [5:0] ev;
    logic [7:0] r;
    ev = ext;
    for (int m = 0; m < 8; m++)
      if (ovf[m] && m_link[m] >= 3'd1 && m_link[m] <= 3'd6) ev[m_link[m]-3'd1] = 1'b1;
    ev = ev & IMPL[5:0];
    r = '0;
    for (int m = 0; m < 8; m++) begin
      if (m_capt[m] == 3'd7) r[m] = swe && IMPL[6] && (sws == sec_of(m));
      else if (m_capt[m] != 3'd0) r[m] = ev[m_capt[m]-3'd1];
      if (!CMASK[m]) r[m] = 1'b0;
    end
    return r;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // one cycle: drive at negedge, compare capture vector at next negedge
  task automatic cyc(string tag, logic [7:0] ovf, logic [5:0] ext, logic swe,
                     logic [1:0] sws, logic we, logic [2:0] idx,
                     logic [2:0] lk, logic [2:0] cp);
    logic [7:0] exp;
    ovf_i = ovf; ext_evt_i = ext; sw_capt_we = swe; sw_capt_sec = sws;
    cfg_we = we; cfg_idx = idx; cfg_link = lk; cfg_capt = cp;
    exp = model(ovf, ext, swe, sws);
    if (we) begin
      m_link[idx] = lk;
      m_capt[idx] = CMASK[idx] ? cp : 3'd0;
    end
    @(negedge clk);
    check(tag, 32'(capt_o), 32'(exp));
  endtask

  task automatic wr(int m, logic [2:0] lk, logic [2:0] cp);
    cyc("R2 cfg", '0, '0, 0, 0, 1, 3'(m), lk, cp);
  endtask

  task automatic idle(string tag);
    cyc(tag, '0, '0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic rdchk(string tag, int m);
    rd_idx = 3'(m);
    #1;
    check(tag, 32'({rd_link, rd_capt}), 32'({m_link[m], m_capt[m]}));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int m = 0; m < 8; m++) begin m_link[m] = 0; m_capt[m] = 0; end
    for (int m = 0; m < 8; m++) mon_sec_i[2*m +: 2] = sec_of(m);
    rst_n = 0; cfg_we = 0; cfg_idx = 0; cfg_link = 0; cfg_capt = 0; rd_idx = 0;
    ovf_i = 0; ext_evt_i = 0; sw_capt_we = 0; sw_capt_sec = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 capt_o", 32'(capt_o), 0);
    for (int m = 0; m < 8; m++) rdchk("R1 selectors", m);
    // R4 select 0 with all sources active
    cyc("R4", 8'hFF, 6'h3F, 1, 0, 0, 0, 0, 0);
    // R5 external event 1 to monitor 0
    wr(0, 0, 1);
    rdchk("R2 readback", 0);
    cyc("R5 ext1", '0, 6'h01, 0, 0, 0, 0, 0, 0);
    check("R5 pulse", 32'(capt_o[0]), 1);
    idle("R5 drop");
    // R6 linked overflow: monitor1 links to event3, monitor2 listens
    wr(1, 3, 0); wr(2, 0, 3);
    cyc("R6 link", 8'h02, '0, 0, 0, 0, 0, 0, 0);
    check("R6 pulse", 32'(capt_o[2]), 1);
    // R7 reserved and none codes
    wr(1, 7, 0);
    cyc("R7 rsvd", 8'h02, '0, 0, 0, 0, 0, 0, 0);
    check("R7 silent", 32'(capt_o), 0);
    wr(1, 0, 0);
    cyc("R7 none", 8'h02, '0, 0, 0, 0, 0, 0, 0);
    // R8 software strobe, monitor3 has tag 3
    wr(3, 0, 7);
    cyc("R8 match", '0, '0, 1, 2'd3, 0, 0, 0, 0);
    check("R8 pulse", 32'(capt_o[3]), 1);
    cyc("R8 mismatch", '0, '0, 1, 2'd1, 0, 0, 0, 0);
    check("R8 quiet", 32'(capt_o[3]), 0);
    // R9 event 6 unimplemented: external and linked
    wr(4, 0, 6); wr(5, 6, 0);
    cyc("R9 ext6", '0, 6'h20, 0, 0, 0, 0, 0, 0);
    check("R9 quiet", 32'(capt_o[4]), 0);
    cyc("R9 link6", 8'h20, '0, 0, 0, 0, 0, 0, 0);
    // R3 monitor 7 without capture support
    wr(7, 2, 2);
    rdchk("R3 readback", 7);
    cyc("R3 ext2", '0, 6'h02, 0, 0, 0, 0, 0, 0);
    check("R3 quiet", 32'(capt_o[7]), 0);
    // R10 self link plus external copy of the same event
    wr(0, 1, 1);
    cyc("R10 self", 8'h01, 6'h01, 0, 0, 0, 0, 0, 0);
    check("R10 single", 32'(capt_o[0]), 1);
    idle("R10 one cycle");
    // out-of-range write index is not possible with 3 bits for 8 monitors; random mix
    for (int i = 0; i < 400; i++) begin
      logic [7:0] ov;
      logic [5:0] ex;
      ov = ($urandom % 4 == 0) ? 8'($urandom) : 8'h00;
      ex = ($urandom % 4 == 0) ? 6'($urandom) : 6'h00;
      cyc("R5 R6 R8 random", ov, ex, 1'($urandom % 3 == 0), 2'($urandom),
          1'($urandom % 3 == 0), 3'($urandom), 3'($urandom), 3'($urandom));
      if (i % 50 == 0) rdchk("R2 random readback", int'($urandom % 8));
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule